// File: doc/BRIEF.md
# Sticky and Level Alarm Unit

This block watches a set of monitored quantities and keeps a six-bit alarm status word. Two of the bits are level alarms that simply follow a comparison each cycle: one is high while an event counter is at or above its threshold, the other while a real-time seconds value is at or above its threshold. Four bits are sticky: they are set by a crossing or an event and stay set until the host clears them. The sticky conditions are an event rate per second above a limit, a positive ADC average above a limit, a negative ADC average above a limit, and any change of level on an asynchronous general-purpose pin.

The host loads thresholds, an enable mask and write-one-to-clear requests through a single write port with a three-bit selector. A combinational search-response flag is high whenever any status bit is set whose mask bit is also set; it tells the bus logic whether the device must answer a conditional search.

Top module: `alarm_monitor`

## Requirements
- R1: After reset the status word, the mask and the search-response flag are all zero, and every threshold holds its all-ones value, so no alarm is active.
- R2: Status bit 0 is 1 in the cycle after `cntVal` is greater than or equal to the count threshold (selector 0), and returns to 0 by itself in the cycle after the condition ends.
- R3: Status bit 1 is 1 in the cycle after `rtcVal` is greater than or equal to the clock threshold (selector 1), and returns to 0 by itself once the condition ends.
- R4: Counter event pulses on `cntEdge` are counted between ticks of `secTick`; a pulse in the tick cycle belongs to the closing window. On a tick, if the window total is strictly above the rate threshold (selector 2), status bit 2 sets in the next cycle, and the count restarts from zero.
- R5: Status bit 3 sets when `adcPos` is strictly above the positive threshold (selector 3), and status bit 4 sets when `adcNeg` is strictly above the negative threshold (selector 4); both stay set after the condition ends.
- R6: Any level change on `pioPin` sets status bit 5 three clock edges after the pin moves (two synchroniser stages and one edge detect stage); it stays set while the pin is stable.
- R7: A write with selector 6 clears each sticky bit (bits 2 to 5) whose `wrData` bit is 1; level bits 0 and 1 are not affected by such a write.
- R8: When a sticky bit's set condition and a clear request for that bit occur in the same cycle, the bit stays set.
- R9: `searchHit` is 1 exactly when at least one status bit is 1 and its mask bit is 1; the mask is loaded from `wrData[5:0]` with selector 5 and takes effect in the next cycle.
- R10: A threshold write takes effect at the write edge, so comparisons use it from the following cycle; a write with selector 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 3 | Write target: 0 count, 1 clock, 2 rate, 3 positive, 4 negative thresholds, 5 mask, 6 clear, 7 none |
| wrData | input | 32 | Host write data |
| cntVal | input | 32 | Monitored event counter value |
| rtcVal | input | 32 | Monitored seconds value |
| adcPos | input | 16 | Positive ADC average |
| adcNeg | input | 16 | Negative ADC average |
| secTick | input | 1 | One-cycle pulse marking the end of each second |
| cntEdge | input | 1 | One-cycle pulse per counted event |
| pioPin | input | 1 | Asynchronous monitored pin |
| statusOut | output | 6 | Alarm status word |
| searchHit | output | 1 | Conditional-search response flag |

## Verification
The assertions assume that `secTick` and `cntEdge` are single-cycle pulses synchronous to `clk`, that the monitored values change only between clock edges, and that `pioPin` is low while reset is applied so the synchroniser starts from a settled level. The stimulus drives every input one nanosecond after a rising edge, keeps event and tick pulses exactly one cycle wide, holds the pin low through reset, and keeps each pin level for at least three cycles so every change passes the synchroniser before the next one.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_ALARMS = 6;
  localparam int NUM_THR    = 5;
  localparam int SEL_W      = 3;

  localparam int B_COUNT = 0;
  localparam int B_CLOCK = 1;
  localparam int B_RATE  = 2;
  localparam int B_POS   = 3;
  localparam int B_NEG   = 4;
  localparam int B_PIN   = 5;

  localparam logic [NUM_ALARMS-1:0] STICKY_BITS = 6'b111100;

  localparam logic [SEL_W-1:0] SEL_THR_COUNT = 3'd0;
  localparam logic [SEL_W-1:0] SEL_THR_CLOCK = 3'd1;
  localparam logic [SEL_W-1:0] SEL_THR_RATE  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_THR_POS   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_THR_NEG   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MASK      = 3'd5;
  localparam logic [SEL_W-1:0] SEL_CLEAR     = 3'd6;

  typedef struct packed {
    logic [NUM_THR-1:0] loadThr;
    logic               loadMask;
    logic               clearReq;
    logic               pinChange;
    logic               tickNow;
    logic               edgeNow;
  } alarmStrobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             pioPin,
  input  logic             secTick,
  input  logic             cntEdge,
  output alarmStrobe_t     strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  // Two-flop synchroniser chain followed by one edge-detect flop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[LAST-1:0], pioPin};
      prevQ <= syncQ[LAST];
    end
  end

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      strobe.loadThr[i] = wrEn && (wrSel == SEL_W'(i));
    end
    strobe.loadMask  = wrEn && (wrSel == SEL_MASK);
    strobe.clearReq  = wrEn && (wrSel == SEL_CLEAR);
    strobe.pinChange = syncQ[LAST] ^ prevQ;
    strobe.tickNow   = secTick;
    strobe.edgeNow   = cntEdge;
  end
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RTC_W  = 32,
  parameter int ADC_W  = 16,
  parameter int RATE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  alarmStrobe_t          strobe,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [CNT_W-1:0]      cntVal,
  input  logic [RTC_W-1:0]      rtcVal,
  input  logic [ADC_W-1:0]      adcPos,
  input  logic [ADC_W-1:0]      adcNeg,
  output logic [NUM_ALARMS-1:0] statusQ,
  output logic                  searchHit,
  output logic [CNT_W-1:0]      thrCountQ,
  output logic [RTC_W-1:0]      thrClockQ,
  output logic [ADC_W-1:0]      thrPosQ
);
  logic [RATE_W-1:0]     thrRateQ;
  logic [ADC_W-1:0]      thrNegQ;
  logic [NUM_ALARMS-1:0] maskQ;
  logic [RATE_W-1:0]     rateCountQ;
  logic [RATE_W:0]       windowTotal;
  logic [NUM_ALARMS-1:0] condVec;
  logic [NUM_ALARMS-1:0] clearVec;
  logic [NUM_ALARMS-1:0] statusD;

  // Threshold and mask registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrCountQ <= '1;
      thrClockQ <= '1;
      thrRateQ  <= '1;
      thrPosQ   <= '1;
      thrNegQ   <= '1;
      maskQ     <= '0;
    end else begin
      if (strobe.loadThr[SEL_THR_COUNT]) thrCountQ <= wrData[CNT_W-1:0];
      if (strobe.loadThr[SEL_THR_CLOCK]) thrClockQ <= wrData[RTC_W-1:0];
      if (strobe.loadThr[SEL_THR_RATE])  thrRateQ  <= wrData[RATE_W-1:0];
      if (strobe.loadThr[SEL_THR_POS])   thrPosQ   <= wrData[ADC_W-1:0];
      if (strobe.loadThr[SEL_THR_NEG])   thrNegQ   <= wrData[ADC_W-1:0];
      if (strobe.loadMask)               maskQ     <= wrData[NUM_ALARMS-1:0];
    end
  end

  // Events per window; a pulse in the tick cycle closes with the window.
  assign windowTotal = {1'b0, rateCountQ} + (RATE_W+1)'(strobe.edgeNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateCountQ <= '0;
    end else if (strobe.tickNow) begin
      rateCountQ <= '0;
    end else if (strobe.edgeNow && (rateCountQ != '1)) begin
      rateCountQ <= rateCountQ + 1'b1;
    end
  end

  always_comb begin
    condVec          = '0;
    condVec[B_COUNT] = cntVal >= thrCountQ;
    condVec[B_CLOCK] = rtcVal >= thrClockQ;
    condVec[B_RATE]  = strobe.tickNow && (windowTotal > {1'b0, thrRateQ});
    condVec[B_POS]   = adcPos > thrPosQ;
    condVec[B_NEG]   = adcNeg > thrNegQ;
    condVec[B_PIN]   = strobe.pinChange;
    clearVec = strobe.clearReq ? (wrData[NUM_ALARMS-1:0] & STICKY_BITS) : '0;
  end

  // Each bit is built as a level follower or a sticky latch.
  for (genvar g = 0; g < NUM_ALARMS; g++) begin : gBit
    if (STICKY_BITS[g]) begin : gSticky
      assign statusD[g] = (statusQ[g] & ~clearVec[g]) | condVec[g];
    end else begin : gLevel
      assign statusD[g] = condVec[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

  assign searchHit = |(statusQ & maskQ);
endmodule

// File: rtl/alarm_monitor.sv
module alarm_monitor
  import alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RTC_W  = 32,
  parameter int ADC_W  = 16,
  parameter int RATE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [SEL_W-1:0]      wrSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [CNT_W-1:0]      cntVal,
  input  logic [RTC_W-1:0]      rtcVal,
  input  logic [ADC_W-1:0]      adcPos,
  input  logic [ADC_W-1:0]      adcNeg,
  input  logic                  secTick,
  input  logic                  cntEdge,
  input  logic                  pioPin,
  output logic [NUM_ALARMS-1:0] statusOut,
  output logic                  searchHit
);
  alarmStrobe_t     strobe;
  logic [CNT_W-1:0] thrCountQ;
  logic [RTC_W-1:0] thrClockQ;
  logic [ADC_W-1:0] thrPosQ;

  alarm_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .pioPin(pioPin), .secTick(secTick), .cntEdge(cntEdge), .strobe(strobe)
  );

  alarm_dp #(
    .CNT_W(CNT_W), .RTC_W(RTC_W), .ADC_W(ADC_W), .RATE_W(RATE_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cntVal(cntVal), .rtcVal(rtcVal), .adcPos(adcPos), .adcNeg(adcNeg),
    .statusQ(statusOut), .searchHit(searchHit),
    .thrCountQ(thrCountQ), .thrClockQ(thrClockQ), .thrPosQ(thrPosQ)
  );
endmodule

// File: rtl/alarm_monitor_chk.sv
module alarm_monitor_chk
  import alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RTC_W  = 32,
  parameter int ADC_W  = 16,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [SEL_W-1:0]      wrSel,
  input logic [DATA_W-1:0]     wrData,
  input logic [CNT_W-1:0]      cntVal,
  input logic [RTC_W-1:0]      rtcVal,
  input logic [ADC_W-1:0]      adcPos,
  input logic [NUM_ALARMS-1:0] statusOut,
  input logic                  searchHit,
  input logic [CNT_W-1:0]      thrCountQ,
  input logic [RTC_W-1:0]      thrClockQ,
  input logic [ADC_W-1:0]      thrPosQ
);
  logic clrPos, clrPin;
  assign clrPos = wrEn && (wrSel == SEL_CLEAR) && wrData[B_POS];
  assign clrPin = wrEn && (wrSel == SEL_CLEAR) && wrData[B_PIN];

  a_r2_count_level: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusOut[B_COUNT] == ($past(cntVal) >= $past(thrCountQ)));

  a_r3_clock_level: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusOut[B_CLOCK] == ($past(rtcVal) >= $past(thrClockQ)));

  a_r5_pos_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[B_POS] && !clrPos) |=> statusOut[B_POS]);

  a_r6_pin_holds: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[B_PIN] && !clrPin) |=> statusOut[B_PIN]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (adcPos > thrPosQ) |=> statusOut[B_POS]);

  a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrSel == SEL_MASK) && (wrData[NUM_ALARMS-1:0] == '0)) |=> !searchHit);
endmodule

bind alarm_monitor alarm_monitor_chk #(
  .CNT_W(CNT_W), .RTC_W(RTC_W), .ADC_W(ADC_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .cntVal(cntVal), .rtcVal(rtcVal), .adcPos(adcPos),
  .statusOut(statusOut), .searchHit(searchHit),
  .thrCountQ(thrCountQ), .thrClockQ(thrClockQ), .thrPosQ(thrPosQ)
);

// File: tb/tb_alarm_monitor.sv
module tb_alarm_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] cntVal = '0;
  logic [31:0] rtcVal = '0;
  logic [15:0] adcPos = '0;
  logic [15:0] adcNeg = '0;
  logic        secTick = 1'b0;
  logic        cntEdge = 1'b0;
  logic        pioPin = 1'b0;
  logic [5:0]  statusOut;
  logic        searchHit;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  string      tagQ[$];
  logic [5:0] statQ[$];
  logic       hitQ[$];

  logic [5:0] model = '0;
  logic [5:0] mdlMask = '0;

  always #10 clk = ~clk;

  alarm_monitor dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cntVal(cntVal), .rtcVal(rtcVal), .adcPos(adcPos), .adcNeg(adcNeg),
    .secTick(secTick), .cntEdge(cntEdge), .pioPin(pioPin),
    .statusOut(statusOut), .searchHit(searchHit)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectNow(input string tag);
    tagQ.push_back(tag);
    statQ.push_back(model);
    hitQ.push_back(|(model & mdlMask));
  endtask

  task automatic hostWrite(input logic [2:0] sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    step();
    wrEn = 1'b0; wrSel = '0; wrData = '0;
  endtask

  // Monitor: compares queued expectations away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (tagQ.size() > 0) begin
        string      t;
        logic [5:0] s;
        logic       h;
        t = tagQ.pop_front();
        s = statQ.pop_front();
        h = hitQ.pop_front();
        checks++;
        if (statusOut !== s || searchHit !== h) begin
          fails++;
          $display("FAIL %s: status=%b hit=%b expected status=%b hit=%b",
                   t, statusOut, searchHit, s, h);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    expectNow("R1 reset state");
    step(); expectNow("R1 idle after reset");

    // R2 counter level
    hostWrite(3'd0, 32'd100);
    cntVal = 99;  step(); expectNow("R2 below threshold");
    cntVal = 100; step(); model[0] = 1'b1; expectNow("R2 at threshold");
    cntVal = 50;  step(); model[0] = 1'b0; expectNow("R2 self clear");

    // R3 clock level
    hostWrite(3'd1, 32'd5000);
    rtcVal = 5000; step(); model[1] = 1'b1; expectNow("R3 at threshold");
    rtcVal = 4999; step(); model[1] = 1'b0; expectNow("R3 self clear");
    rtcVal = 6000; step(); model[1] = 1'b1; expectNow("R3 above threshold");
    hostWrite(3'd6, 32'h3F); expectNow("R7 level bit ignores clear");

    // R4 rate alarm
    hostWrite(3'd2, 32'd3);
    secTick = 1'b1; step(); secTick = 1'b0; expectNow("R4 empty window");
    cntEdge = 1'b1; repeat (3) step(); cntEdge = 1'b0;
    secTick = 1'b1; step(); secTick = 1'b0; expectNow("R4 equal to limit");
    cntEdge = 1'b1; repeat (3) step();
    secTick = 1'b1; step(); secTick = 1'b0; cntEdge = 1'b0;
    model[2] = 1'b1; expectNow("R4 edge in tick cycle counts");
    secTick = 1'b1; step(); secTick = 1'b0; expectNow("R4 sticky over quiet window");
    hostWrite(3'd6, 32'h04); model[2] = 1'b0; expectNow("R7 clear rate bit");

    // R5 ADC averages
    hostWrite(3'd3, 32'd200);
    adcPos = 200; step(); expectNow("R5 positive equal not above");
    adcPos = 201; step(); model[3] = 1'b1; expectNow("R5 positive above");
    adcPos = 0;   step(); expectNow("R5 positive sticky");
    hostWrite(3'd4, 32'd50);
    adcNeg = 51; step(); model[4] = 1'b1; expectNow("R5 negative above");
    adcNeg = 0;  step(); expectNow("R5 negative sticky");

    // R8 set beats clear
    adcPos = 201;
    hostWrite(3'd6, 32'h08); expectNow("R8 set wins over clear");
    adcPos = 0;
    hostWrite(3'd6, 32'h08); model[3] = 1'b0; expectNow("R7 clear positive bit");
    hostWrite(3'd7, 32'h3F); expectNow("R10 selector 7 ignored");

    // R6 pin change through synchroniser
    pioPin = 1'b1;
    step(); step(); expectNow("R6 not yet after two edges");
    step(); model[5] = 1'b1; expectNow("R6 rise detected on third edge");
    hostWrite(3'd6, 32'h20); model[5] = 1'b0; expectNow("R7 clear pin bit");
    pioPin = 1'b0;
    repeat (3) step(); model[5] = 1'b1; expectNow("R6 fall detected");

    // R9 mask and search response
    hostWrite(3'd5, 32'h08); mdlMask = 6'h08; expectNow("R9 masked bit clear");
    hostWrite(3'd5, 32'h10); mdlMask = 6'h10; expectNow("R9 negative bit enabled");
    hostWrite(3'd5, 32'h00); mdlMask = 6'h00; expectNow("R9 mask zero");
    hostWrite(3'd5, 32'h02); mdlMask = 6'h02; expectNow("R9 level bit enabled");
    rtcVal = 0; step(); model[1] = 1'b0; expectNow("R9 follows level bit");

    // R10 threshold write latency
    hostWrite(3'd0, 32'd40); expectNow("R10 old threshold at write edge");
    step(); model[0] = 1'b1; expectNow("R10 new threshold next cycle");

    step(); step();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule